// File: doc/BRIEF.md
# Flash Timing Clock Divider with Scan-Loaded Erase Trigger

This block derives the slow timing clock that a flash controller needs for its program and erase pulses. It produces the clock as a one-cycle enable in the system clock domain. The divider setting is a 7-bit word. Bit 6 turns on a divide-by-8 prescaler. Bits 5:0 hold a ratio value N, so the rate divides by N+1. The divide chain always starts from half the system clock.

The setting arrives serially through a test data register. A test access port drives this register through select, shift, serial-in and update signals. The block treats the select input as meaning that the recovery instruction is active. An update copies the shifted word into a holding register and restarts the divider. If the resulting rate is acceptable, the update also arms a mass-erase.

The rate is acceptable when it lies above 150 kHz and at or below 200 kHz for the configured system frequency. The prescaler bit must also match the rule for the flash input clock: it is set exactly when half the system clock exceeds 12.8 MHz. Once armed, the erase starts when the run-test/idle indicator is seen. It then runs for a modelled number of cycles. It is abandoned if the indicator drops before it finishes.

Top module: `flash_tclk_divider`

## Requirements
- R1: After reset the holding register is zero, so `tclk_en`, `erase_req`, `erase_busy` and `cfg_err` are all low and stay low until a word is loaded.
- R2: While `dr_sel` and `dr_shift` are high, the scan register shifts right by one bit per cycle. It takes `dr_si` into bit 6, and `dr_so` always shows bit 0, so data moves least significant bit first. With `dr_sel` low, shift and update have no effect. The holding register changes only on a cycle with `dr_sel` and `dr_update` both high.
- R3: With bit 6 of the loaded word clear and N = bits 5:0 nonzero, `tclk_en` pulses once every 2·(N+1) system cycles.
- R4: With bit 6 set and N nonzero, `tclk_en` pulses once every 16·(N+1) system cycles. Each pulse is one cycle wide.
- R5: A loaded word whose bits 5:0 are zero produces no `tclk_en` pulses, whatever bit 6 holds.
- R6: On each update, `cfg_err` is set if the word fails either rule below, and cleared if it passes both. The rate rule: SYS_HZ/(2·P·(N+1)) must be above 150 kHz and at most 200 kHz, where P is 8 when bit 6 is set and 1 otherwise. The prescaler rule: bit 6 must equal (SYS_HZ/2 > 12.8 MHz). With the default 8 MHz, the words 0x13 to 0x19 pass, and 0x12, 0x1A, 0x42 and 0x00 fail.
- R7: An update with a passing word arms the erase. The next cycle that sees `tap_idle` high starts it. `erase_req` is then high for exactly one cycle, and that is the first cycle of `erase_busy`. A failing word never produces `erase_req`.
- R8: If `tap_idle` stays high, `erase_busy` lasts exactly ERASE_CYCLES cycles. `tclk_en` keeps pulsing throughout.
- R9: If `tap_idle` drops during an erase, `erase_busy` falls on the next cycle.
- R10: An erase starts only from a fresh update. `tap_idle` without an armed word, or after an erase has ended or been aborted, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dr_sel | input | 1 | Recovery instruction active and this data register selected |
| dr_shift | input | 1 | Shift enable for the scan register |
| dr_si | input | 1 | Serial data in |
| dr_update | input | 1 | Update pulse that copies the scan register into the holding register |
| tap_idle | input | 1 | Test controller is in run-test/idle |
| dr_so | output | 1 | Serial data out (bit 0 of the scan register) |
| tclk_en | output | 1 | One-cycle enable at the flash timing rate |
| erase_req | output | 1 | One-cycle mass-erase request strobe |
| erase_busy | output | 1 | Erase in progress |
| cfg_err | output | 1 | Last loaded word failed the rate or prescaler rule |

## Verification
Each result has a fixed latency after the update edge:
- The holding register takes the new word at that edge.
- The divider restarts and `cfg_err` settles one edge later.
- The erase can start no earlier than two edges after the update.
- The request and busy flag appear in the cycle after `tap_idle` is sampled high.
- Busy falls one cycle after `tap_idle` is seen low.

The bench drives inputs and samples outputs on falling edges, so each rising edge separates one stimulus from the next observation. Periods are measured as the distance between two consecutive `tclk_en` pulses rather than from the load, which makes them independent of the restart phase. Erase length is counted from the cycle where `erase_req` is first observed.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   typedef enum logic [1:0] {
      ER_IDLE  = 2'd0,
      ER_ARMED = 2'd1,
      ER_BUSY  = 2'd2
   } erase_state_e;

   // Rate and prescaler rule for a divider word: ratio in v[div_w-1:0],
   // prescale enable in v[div_w].
   function automatic logic word_ok(
      input logic [15:0]       v,
      input int                div_w,
      input longint unsigned   sys_hz,
      input longint unsigned   fmin_hz,
      input longint unsigned   fmax_hz,
      input longint unsigned   pre_thr_hz,
      input int                pre_ratio
   );
      longint unsigned period;
      longint unsigned ratio;
      logic            pre_bit;
      logic            need_pre;
      ratio    = 64'(v & 16'((1 << div_w) - 1));
      pre_bit  = v[div_w];
      need_pre = (sys_hz / 64'd2) > pre_thr_hz;
      period   = (ratio + 64'd1) * 64'd2;
      if (pre_bit) period = period * 64'(pre_ratio);
      return (pre_bit == need_pre) &&
             (sys_hz > fmin_hz * period) &&
             (sys_hz <= fmax_hz * period);
   endfunction

endpackage

// File: rtl/fcd_scan_dr.sv
module fcd_scan_dr #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel,
   input  logic         shift,
   input  logic         si,
   input  logic         update,
   output logic         so,
   output logic [W-1:0] hold_o,
   output logic         load_o
);

   if (W < 2) begin : g_bad_w
      $error("fcd_scan_dr: W must be at least 2");
   end

   logic [W-1:0] shreg_q;
   logic [W-1:0] hold_q;
   logic         load_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
      end else if (sel && shift) begin
         shreg_q <= {si, shreg_q[W-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         load_q <= 1'b0;
      end else begin
         load_q <= sel && update;
         if (sel && update) hold_q <= shreg_q;
      end
   end

   assign so     = shreg_q[0];
   assign hold_o = hold_q;
   assign load_o = load_q;

   AST_HOLD_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel && update) |=> $stable(hold_q)); // R2

   AST_SHREG_STILL_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> $stable(shreg_q)); // R2

endmodule

// File: rtl/fcd_divider.sv
module fcd_divider #(
   parameter int DIV_W     = 6,
   parameter int PRE_RATIO = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [DIV_W:0] cfg,
   output logic         en_o
);

   localparam int PRE_W = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;

   if (DIV_W < 1) begin : g_bad_div
      $error("fcd_divider: DIV_W must be at least 1");
   end
   if (PRE_RATIO < 1) begin : g_bad_pre
      $error("fcd_divider: PRE_RATIO must be at least 1");
   end

   logic [DIV_W:0]   cfg_q;
   logic [DIV_W-1:0] ratio;
   logic             run;
   logic             half_q;
   logic             tick2;
   logic             tick_in;
   logic [DIV_W-1:0] main_q;
   logic             en_q;

   assign ratio = cfg_q[DIV_W-1:0];
   assign run   = (ratio != '0);
   assign tick2 = half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         half_q <= 1'b0;
      end else if (load) begin
         cfg_q  <= cfg;
         half_q <= 1'b0;
      end else begin
         half_q <= run ? ~half_q : 1'b0;
      end
   end

   if (PRE_RATIO > 1) begin : g_prescale
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
         end else if (load) begin
            pre_q <= '0;
         end else if (tick2) begin
            pre_q <= (pre_q == PRE_W'(PRE_RATIO - 1)) ? '0 : pre_q + 1'b1;
         end
      end
      assign tick_in = tick2 && (!cfg_q[DIV_W] || (pre_q == PRE_W'(PRE_RATIO - 1)));
   end else begin : g_no_prescale
      assign tick_in = tick2;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_q <= '0;
         en_q   <= 1'b0;
      end else if (load) begin
         main_q <= '0;
         en_q   <= 1'b0;
      end else begin
         en_q <= tick_in && (main_q == ratio);
         if (tick_in) main_q <= (main_q == ratio) ? '0 : main_q + 1'b1;
      end
   end

   assign en_o = en_q;

   AST_EN_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> !en_q); // R4

   AST_EN_ZERO_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> !en_q); // R5

endmodule

// File: rtl/fcd_erase_seq.sv
module fcd_erase_seq
   import fcd_pkg::*;
#(
   parameter int ERASE_CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic cfg_ok,
   input  logic tap_idle,
   output logic req_o,
   output logic busy_o,
   output logic err_o
);

   localparam int CW = $clog2(ERASE_CYCLES + 1);

   if (ERASE_CYCLES < 2) begin : g_bad_len
      $error("fcd_erase_seq: ERASE_CYCLES must be at least 2");
   end

   erase_state_e st_q;
   logic [CW-1:0] cnt_q;
   logic          req_q;
   logic          err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (load) begin
         err_q <= !cfg_ok;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ER_IDLE;
         cnt_q <= '0;
         req_q <= 1'b0;
      end else begin
         req_q <= 1'b0;
         case (st_q)
            ER_IDLE, ER_ARMED: begin
               if (load) begin
                  st_q <= cfg_ok ? ER_ARMED : ER_IDLE;
               end else if (st_q == ER_ARMED && tap_idle) begin
                  st_q  <= ER_BUSY;
                  req_q <= 1'b1;
                  cnt_q <= CW'(ERASE_CYCLES - 1);
               end
            end
            ER_BUSY: begin
               if (!tap_idle || cnt_q == '0) begin
                  st_q <= ER_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: st_q <= ER_IDLE;
         endcase
      end
   end

   assign req_o  = req_q;
   assign busy_o = (st_q == ER_BUSY);
   assign err_o  = err_q;

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> !req_q); // R7

   AST_REQ_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> $past(tap_idle)); // R7

   AST_NO_ERASE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> !err_q); // R6

   AST_ABORT_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !tap_idle) |=> !busy_o); // R9

   AST_BUSY_STARTS_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> (!busy_o || req_q)); // R10

endmodule

// File: rtl/flash_tclk_divider.sv
module flash_tclk_divider
   import fcd_pkg::*;
#(
   parameter int              DIV_W        = 6,
   parameter int              PRE_RATIO    = 8,
   parameter longint unsigned SYS_HZ       = 64'd8_000_000,
   parameter longint unsigned FMIN_HZ      = 64'd150_000,
   parameter longint unsigned FMAX_HZ      = 64'd200_000,
   parameter longint unsigned PRE_THR_HZ   = 64'd12_800_000,
   parameter int              ERASE_CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dr_sel,
   input  logic dr_shift,
   input  logic dr_si,
   input  logic dr_update,
   input  logic tap_idle,
   output logic dr_so,
   output logic tclk_en,
   output logic erase_req,
   output logic erase_busy,
   output logic cfg_err
);

   localparam int WORD_W = DIV_W + 1;

   if (WORD_W > 16) begin : g_bad_word
      $error("flash_tclk_divider: DIV_W must not exceed 15");
   end
   if (FMIN_HZ >= FMAX_HZ) begin : g_bad_window
      $error("flash_tclk_divider: FMIN_HZ must be below FMAX_HZ");
   end

   logic [WORD_W-1:0] hold;
   logic              load;
   logic              ok;

   fcd_scan_dr #(.W(WORD_W)) u_scan (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (dr_sel),
      .shift  (dr_shift),
      .si     (dr_si),
      .update (dr_update),
      .so     (dr_so),
      .hold_o (hold),
      .load_o (load)
   );

   assign ok = word_ok(16'(hold), DIV_W, SYS_HZ, FMIN_HZ, FMAX_HZ, PRE_THR_HZ, PRE_RATIO);

   fcd_divider #(.DIV_W(DIV_W), .PRE_RATIO(PRE_RATIO)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .cfg   (hold),
      .en_o  (tclk_en)
   );

   fcd_erase_seq #(.ERASE_CYCLES(ERASE_CYCLES)) u_erase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .cfg_ok   (ok),
      .tap_idle (tap_idle),
      .req_o    (erase_req),
      .busy_o   (erase_busy),
      .err_o    (cfg_err)
   );

endmodule

// File: tb/flash_tclk_divider_tb.sv
module flash_tclk_divider_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ERASE_N    = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dr_sel = 1'b0, dr_shift = 1'b0, dr_si = 1'b0, dr_update = 1'b0, tap_idle = 1'b0;
   logic dr_so, tclk_en, erase_req, erase_busy, cfg_err;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_tclk_divider #(.ERASE_CYCLES(ERASE_N)) dut_i (
      .clk(clk), .rst_n(rst_n), .dr_sel(dr_sel), .dr_shift(dr_shift),
      .dr_si(dr_si), .dr_update(dr_update), .tap_idle(tap_idle),
      .dr_so(dr_so), .tclk_en(tclk_en), .erase_req(erase_req),
      .erase_busy(erase_busy), .cfg_err(cfg_err)
   );

   task automatic chk(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic load_word(input logic [6:0] v);
      dr_sel = 1'b1;
      for (int i = 0; i < 7; i++) begin
         dr_si = v[i]; dr_shift = 1'b1;
         step();
      end
      dr_shift = 1'b0; dr_update = 1'b1;
      step();
      dr_update = 1'b0; dr_sel = 1'b0;
      step(2);
   endtask

   // Count tclk_en pulses over n cycles
   task automatic count_pulses(input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         step();
         if (tclk_en) cnt++;
      end
   endtask

   task automatic t_reset();
      int p;
      count_pulses(60, p);
      chk(p == 0, "R1 tclk_en after reset", p, 0);
      chk(erase_busy == 0 && erase_req == 0, "R1 erase idle after reset", erase_busy, 0);
      chk(cfg_err == 0, "R1 cfg_err after reset", cfg_err, 0);
   endtask

   task automatic t_shift();
      logic [6:0] pat = 7'h2D;
      logic [6:0] got;
      int p;
      dr_sel = 1'b1;
      for (int i = 0; i < 7; i++) begin
         dr_si = pat[i]; dr_shift = 1'b1; step();
      end
      dr_shift = 1'b0; dr_sel = 1'b0;
      // unselected shifting must not disturb the scan register
      dr_shift = 1'b1; dr_si = 1'b1; step(5); dr_shift = 1'b0;
      dr_sel = 1'b1;
      for (int i = 0; i < 7; i++) begin
         got[i] = dr_so;
         dr_si = 1'b0; dr_shift = 1'b1; step();
      end
      dr_shift = 1'b0; dr_sel = 1'b0;
      chk(got == pat, "R2 serial readback LSB first", got, pat);
      // unselected update must not load
      dr_update = 1'b1; step(); dr_update = 1'b0;
      count_pulses(60, p);
      chk(p == 0 && cfg_err == 0, "R2 update ignored without select", p, 0);
   endtask

   task automatic t_period(input logic [6:0] v, input int exp_per, input bit exp_err, input string req);
      int gap = 0;
      int guard = 0;
      load_word(v);
      chk(cfg_err == exp_err, {req, " R6 cfg_err"}, cfg_err, exp_err);
      while (!tclk_en && guard < 4000) begin step(); guard++; end
      step();
      chk(tclk_en == 0, {req, " R4 pulse width"}, tclk_en, 0);
      gap = 1;
      while (!tclk_en && gap < 4000) begin step(); gap++; end
      chk(gap == exp_per, {req, " period"}, gap, exp_per);
   endtask

   task automatic t_zero();
      int p;
      load_word(7'h00);
      count_pulses(300, p);
      chk(p == 0, "R5 ratio zero no pulses", p, 0);
      chk(cfg_err == 1, "R6 word 0x00 rejected", cfg_err, 1);
      load_word(7'h40);
      count_pulses(300, p);
      chk(p == 0, "R5 ratio zero with prescale no pulses", p, 0);
   endtask

   task automatic t_erase();
      int wait_n = 0;
      int busy_n = 0;
      int p = 0;
      bit seen = 0;
      load_word(7'h13);
      step(3);
      chk(erase_busy == 0, "R10 armed but not idle", erase_busy, 0);
      tap_idle = 1'b1;
      while (!erase_req && wait_n < 10) begin step(); wait_n++; end
      chk(erase_req == 1, "R7 erase_req on idle", erase_req, 1);
      chk(erase_busy == 1, "R7 busy with request", erase_busy, 1);
      busy_n = 1;
      if (tclk_en) p++;
      step();
      chk(erase_req == 0, "R7 request one cycle", erase_req, 0);
      while (erase_busy && busy_n < 1000) begin
         busy_n++;
         if (tclk_en) p++;
         step();
      end
      chk(busy_n == ERASE_N, "R8 busy length", busy_n, ERASE_N);
      chk(p >= 2, "R8 tclk_en during erase", p, 2);
      for (int i = 0; i < 60; i++) begin
         step();
         if (erase_busy || erase_req) seen = 1;
      end
      chk(!seen, "R10 no restart without update", seen, 0);
      tap_idle = 1'b0; step();
   endtask

   task automatic t_abort();
      int wait_n = 0;
      bit seen = 0;
      load_word(7'h16);
      tap_idle = 1'b1;
      while (!erase_req && wait_n < 10) begin step(); wait_n++; end
      step(5);
      chk(erase_busy == 1, "R9 busy before exit", erase_busy, 1);
      tap_idle = 1'b0;
      step();
      chk(erase_busy == 0, "R9 busy drops on exit", erase_busy, 0);
      tap_idle = 1'b1;
      for (int i = 0; i < 30; i++) begin
         step();
         if (erase_busy || erase_req) seen = 1;
      end
      chk(!seen, "R10 no restart after abort", seen, 0);
      tap_idle = 1'b0; step();
   endtask

   task automatic t_err_block();
      bit seen = 0;
      load_word(7'h1A);
      chk(cfg_err == 1, "R6 word 0x1A rejected", cfg_err, 1);
      tap_idle = 1'b1;
      for (int i = 0; i < 50; i++) begin
         step();
         if (erase_busy || erase_req) seen = 1;
      end
      chk(!seen, "R7 failing word starts no erase", seen, 0);
      tap_idle = 1'b0; step();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      t_reset();
      t_shift();
      t_period(7'h13, 40, 0, "R3 word 0x13");
      t_period(7'h19, 52, 0, "R3 word 0x19");
      t_period(7'h12, 38, 1, "R3 word 0x12");
      t_period(7'h1A, 54, 1, "R3 word 0x1A");
      t_period(7'h42, 48, 1, "R4 word 0x42");
      t_period(7'h45, 96, 1, "R4 word 0x45");
      t_zero();
      t_erase();
      t_abort();
      t_err_block();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule